// File: doc/BRIEF.md
# Indicator Test Branch Unit

This block keeps a bank of sticky machine condition flags and resolves one uniform conditional branch against them. Anywhere in the machine, a condition raises a one-cycle set pulse on its own flag, and the flag stays on until software clears it. A branch presents a flag number, a polarity and an optional clear request together with a target address. One cycle later the unit reports whether the branch is taken and echoes the target. When the clear request is present, the tested flag is cleared at the same clock edge, using the value that was tested.

A mask register decides which flags may raise an interrupt. The unit registers the OR of all enabled, raised flags as the interrupt request. It also forms a routine address from a programmable base plus the number of the lowest-numbered pending flag. Instruction fetch and the interrupt entry sequence are handled by the surrounding machine.

Top module: `itb_unit`

## Requirements
- R1: After rst_ni is released, all flags, the mask and the base read as zero, and done_o, taken_o, irq_o and irq_addr_o are 0.
- R2: A 1 on set_i[k] at a clock edge makes flag k read as 1 from that edge on. A flag stays 1 until a branch clears it.
- R3: br_sel_i selects flag number br_sel_i (0 to IND_N-1) as the flag under test.
- R4: With br_sense_i = 1 the branch is taken when the selected flag is 1. With br_sense_i = 0 it is taken when the flag is 0.
- R5: done_o is 1 exactly in the cycle after a cycle with br_valid_i = 1. taken_o and target_o belong to that strobe, and taken_o is 0 whenever done_o is 0.
- R6: With br_clr_i = 1, the selected flag is cleared at the strobe's clock edge, after its value was used for the decision. With br_clr_i = 0, the flag is unchanged.
- R7: If a set pulse and a clear of the same flag meet at one edge, the flag ends up set.
- R8: A clear affects only the selected flag. All other flags keep their values.
- R9: irq_o equals the OR over all flags of (flag AND mask), registered once after the flag and mask registers.
- R10: mask_we_i loads mask_wdata_i into the mask. Mask bit k = 1 lets flag k take part in the interrupt request.
- R11: When irq_o = 1, irq_addr_o = base + (lowest k with flag k and mask bit k both 1). When irq_o = 0, irq_addr_o = base. base_we_i loads base_wdata_i into the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | IND_N | One-cycle set pulses, one per flag |
| br_valid_i | input | 1 | Branch strobe |
| br_sel_i | input | SEL_W | Number of the flag under test |
| br_sense_i | input | 1 | 1: taken when flag is on, 0: taken when off |
| br_clr_i | input | 1 | Clear the tested flag |
| br_target_i | input | ADDR_W | Branch target |
| mask_we_i | input | 1 | Mask write enable |
| mask_wdata_i | input | IND_N | New mask value |
| base_we_i | input | 1 | Base write enable |
| base_wdata_i | input | ADDR_W | New interrupt base |
| done_o | output | 1 | Branch result valid |
| taken_o | output | 1 | Branch taken |
| target_o | output | ADDR_W | Target of the resolved branch |
| irq_o | output | 1 | Interrupt request |
| irq_addr_o | output | ADDR_W | Routine address for the pending interrupt |

## Verification
The bench builds the unit with its defaults: 64 flags and a 24-bit address. At this size, every select value can be swept with both polarities and with clear on and off. Every single-bit mask can be swept as well, so each flag's decoder row and priority position is checked. The bench also covers multi-flag patterns that show clear isolation between flags, set-over-clear collisions, and the lowest-index choice of the routine address.

// File: rtl/itb_pkg.sv
package itb_pkg;
  localparam int unsigned IND_N_DEF  = 64;
  localparam int unsigned ADDR_W_DEF = 24;

  typedef enum logic {
    SENSE_OFF = 1'b0,
    SENSE_ON  = 1'b1
  } sense_e;
endpackage

// File: rtl/itb_ind_reg.sv
module itb_ind_reg #(
  parameter int unsigned IND_N = itb_pkg::IND_N_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IND_N-1:0] set_i,
  input  logic [IND_N-1:0] clr_i,
  output logic [IND_N-1:0] ind_o
);
  logic [IND_N-1:0] ind_q;

  for (genvar g = 0; g < IND_N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       ind_q[g] <= 1'b0;
      else if (set_i[g]) ind_q[g] <= 1'b1;   // set wins over clear
      else if (clr_i[g]) ind_q[g] <= 1'b0;
    end

    p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> ind_q[g]);
  end

  assign ind_o = ind_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((ind_q & $past(ind_q)) == $past(ind_q)));
endmodule

// File: rtl/itb_branch_eval.sv
module itb_branch_eval #(
  parameter int unsigned IND_N  = itb_pkg::IND_N_DEF,
  parameter int unsigned ADDR_W = itb_pkg::ADDR_W_DEF,
  localparam int unsigned SEL_W = $clog2(IND_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IND_N-1:0]  ind_i,
  input  logic              valid_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  itb_pkg::sense_e   sense_i,
  input  logic              clr_req_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [IND_N-1:0]  clr_o,
  output logic              done_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o
);
  logic              hit;
  logic              match;
  logic              done_q, taken_q;
  logic [ADDR_W-1:0] target_q;

  assign hit   = ind_i[sel_i];
  assign match = (hit == logic'(sense_i));

  for (genvar g = 0; g < IND_N; g++) begin : g_dec
    assign clr_o[g] = valid_i && clr_req_i && (sel_i == SEL_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      taken_q  <= 1'b0;
      target_q <= '0;
    end else begin
      done_q  <= valid_i;
      taken_q <= valid_i && match;
      if (valid_i) target_q <= target_i;
    end
  end

  assign done_o   = done_q;
  assign taken_o  = taken_q;
  assign target_o = target_q;

  p_clr_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));
  p_done_follows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  p_taken_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> done_o);
endmodule

// File: rtl/itb_irq_gen.sv
module itb_irq_gen #(
  parameter int unsigned IND_N  = itb_pkg::IND_N_DEF,
  parameter int unsigned ADDR_W = itb_pkg::ADDR_W_DEF,
  localparam int unsigned SEL_W = $clog2(IND_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IND_N-1:0]  ind_i,
  input  logic              mask_we_i,
  input  logic [IND_N-1:0]  mask_wdata_i,
  input  logic              base_we_i,
  input  logic [ADDR_W-1:0] base_wdata_i,
  output logic              irq_o,
  output logic [ADDR_W-1:0] irq_addr_o
);
  logic [IND_N-1:0]  mask_q;
  logic [ADDR_W-1:0] base_q;
  logic [IND_N-1:0]  pend;
  logic [SEL_W-1:0]  low_idx;
  logic              any_pend;
  logic              irq_q;
  logic [ADDR_W-1:0] addr_q;

  assign pend     = ind_i & mask_q;
  assign any_pend = |pend;

  // lowest set index wins
  always_comb begin
    low_idx = '0;
    for (int k = IND_N - 1; k >= 0; k--) begin
      if (pend[k]) low_idx = SEL_W'(k);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      base_q <= '0;
      irq_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      if (mask_we_i) mask_q <= mask_wdata_i;
      if (base_we_i) base_q <= base_wdata_i;
      irq_q  <= any_pend;
      addr_q <= any_pend ? base_q + ADDR_W'(low_idx) : base_q;
    end
  end

  assign irq_o      = irq_q;
  assign irq_addr_o = addr_q;

  p_irq_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ind_i & mask_q)) |=> irq_o);
  p_irq_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(ind_i & mask_q)) |=> !irq_o);
  p_mask_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |=> !irq_o);
  p_addr_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_pend && !base_we_i) |=> (irq_addr_o == base_q));
endmodule

// File: rtl/itb_unit.sv
module itb_unit #(
  parameter int unsigned IND_N  = itb_pkg::IND_N_DEF,
  parameter int unsigned ADDR_W = itb_pkg::ADDR_W_DEF,
  localparam int unsigned SEL_W = $clog2(IND_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IND_N-1:0]  set_i,
  input  logic              br_valid_i,
  input  logic [SEL_W-1:0]  br_sel_i,
  input  logic              br_sense_i,
  input  logic              br_clr_i,
  input  logic [ADDR_W-1:0] br_target_i,
  input  logic              mask_we_i,
  input  logic [IND_N-1:0]  mask_wdata_i,
  input  logic              base_we_i,
  input  logic [ADDR_W-1:0] base_wdata_i,
  output logic              done_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o,
  output logic              irq_o,
  output logic [ADDR_W-1:0] irq_addr_o
);
  logic [IND_N-1:0] ind;
  logic [IND_N-1:0] clr;
  itb_pkg::sense_e  sense;

  assign sense = itb_pkg::sense_e'(br_sense_i);

  itb_ind_reg #(.IND_N(IND_N)) u_ind (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_i),
    .clr_i  (clr),
    .ind_o  (ind)
  );

  itb_branch_eval #(.IND_N(IND_N), .ADDR_W(ADDR_W)) u_br (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ind_i     (ind),
    .valid_i   (br_valid_i),
    .sel_i     (br_sel_i),
    .sense_i   (sense),
    .clr_req_i (br_clr_i),
    .target_i  (br_target_i),
    .clr_o     (clr),
    .done_o    (done_o),
    .taken_o   (taken_o),
    .target_o  (target_o)
  );

  itb_irq_gen #(.IND_N(IND_N), .ADDR_W(ADDR_W)) u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ind_i        (ind),
    .mask_we_i    (mask_we_i),
    .mask_wdata_i (mask_wdata_i),
    .base_we_i    (base_we_i),
    .base_wdata_i (base_wdata_i),
    .irq_o        (irq_o),
    .irq_addr_o   (irq_addr_o)
  );
endmodule

// File: tb/tb_itb_unit.sv
`timescale 1ns/1ps
module tb_itb_unit;
  localparam int unsigned N = 64;
  localparam int unsigned AW = 24;
  localparam int unsigned SW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]  set_v = '0;
  logic          br_valid = 1'b0;
  logic [SW-1:0] br_sel = '0;
  logic          br_sense = 1'b0;
  logic          br_clr = 1'b0;
  logic [AW-1:0] br_target = '0;
  logic          mask_we = 1'b0;
  logic [N-1:0]  mask_wdata = '0;
  logic          base_we = 1'b0;
  logic [AW-1:0] base_wdata = '0;
  logic          done, taken, irq;
  logic [AW-1:0] target, irq_addr;

  logic [N-1:0]  ind_m = '0;
  logic [N-1:0]  mask_m = '0;
  logic [AW-1:0] base_m = '0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  itb_unit #(.IND_N(N), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .set_i(set_v),
    .br_valid_i(br_valid), .br_sel_i(br_sel), .br_sense_i(br_sense),
    .br_clr_i(br_clr), .br_target_i(br_target),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata),
    .base_we_i(base_we), .base_wdata_i(base_wdata),
    .done_o(done), .taken_o(taken), .target_o(target),
    .irq_o(irq), .irq_addr_o(irq_addr)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_branch(int sel, bit sense, bit clr, logic [N-1:0] setv, string req);
    logic [AW-1:0] tgt;
    bit exp_taken;
    tgt = AW'(sel * 4099 + 17 + (sense ? 1000 : 0));
    exp_taken = (ind_m[sel] == sense);
    @(negedge clk);
    br_valid = 1'b1; br_sel = SW'(sel); br_sense = sense; br_clr = clr;
    br_target = tgt; set_v = setv;
    @(negedge clk);
    br_valid = 1'b0; br_clr = 1'b0; set_v = '0;
    if (clr) ind_m[sel] = 1'b0;
    ind_m = ind_m | setv;
    chk({req, " done"}, 64'(done), 64'(1));
    chk({req, " taken"}, 64'(taken), 64'(exp_taken));
    chk({req, " target"}, 64'(target), 64'(tgt));
  endtask

  task automatic pulse_set(logic [N-1:0] v);
    @(negedge clk); set_v = v;
    @(negedge clk); set_v = '0;
    ind_m = ind_m | v;
  endtask

  task automatic write_mask(logic [N-1:0] v);
    @(negedge clk); mask_we = 1'b1; mask_wdata = v;
    @(negedge clk); mask_we = 1'b0;
    mask_m = v;
  endtask

  task automatic write_base(logic [AW-1:0] v);
    @(negedge clk); base_we = 1'b1; base_wdata = v;
    @(negedge clk); base_we = 1'b0;
    base_m = v;
  endtask

  task automatic check_irq(string req);
    logic [N-1:0] p;
    logic [AW-1:0] ea;
    @(negedge clk); @(negedge clk);
    p = ind_m & mask_m;
    ea = base_m;
    for (int k = N - 1; k >= 0; k--) if (p[k]) ea = base_m + AW'(k);
    chk({req, " irq"}, 64'(irq), 64'(|p));
    chk({"R11 ", req, " addr"}, 64'(irq_addr), 64'(ea));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", 64'(done), 0);
    chk("R1 taken", 64'(taken), 0);
    chk("R1 irq", 64'(irq), 0);
    chk("R1 irq_addr", 64'(irq_addr), 0);
    do_branch(5, 1'b0, 1'b0, '0, "R1 flags clear");

    // R2 R3 R4 R6 sweep every flag, both senses
    for (int i = 0; i < N; i++) begin
      pulse_set(N'(1) << i);
      do_branch(i, 1'b0, 1'b0, '0, "R4 off-sense on set flag");
      do_branch(i, 1'b1, 1'b1, '0, "R3 on-sense with clear");
      do_branch(i, 1'b1, 1'b0, '0, "R6 cleared flag");
      do_branch(i, 1'b0, 1'b0, '0, "R6 cleared flag off-sense");
    end

    // R8 clear isolation on a checkerboard
    pulse_set({(N/2){2'b10}});
    for (int i = 0; i < N; i++)
      do_branch(i, i % 3 == 0, i % 2 == 0, '0, "R8 mixed pattern");
    for (int i = 0; i < N; i++)
      do_branch(i, 1'b1, 1'b0, '0, "R8 readback");

    // R7 set and clear on the same flag
    for (int i = 0; i < N; i += 7) begin
      do_branch(i, 1'b1, 1'b1, N'(1) << i, "R7 collide");
      do_branch(i, 1'b1, 1'b0, '0, "R7 set wins");
    end
    // R8 set on another flag while clearing one
    do_branch(3, 1'b1, 1'b1, N'(1) << 4, "R8 other set");
    do_branch(4, 1'b1, 1'b0, '0, "R8 other set survives");

    // R5 no strobe, no result
    @(negedge clk);
    chk("R5 idle done", 64'(done), 0);
    chk("R5 idle taken", 64'(taken), 0);

    // R9 R10 R11 interrupt path
    check_irq("R10 mask zero");
    write_base(AW'(24'h00_4000));
    check_irq("R11 base idle");
    for (int i = 0; i < N; i++) begin
      write_mask(N'(1) << i);
      check_irq("R10 single mask");
    end
    write_mask('1);
    check_irq("R9 full mask");
    for (int i = 0; i < N; i += 9) begin
      do_branch(i, 1'b1, 1'b1, '0, "R9 clear pending");
      check_irq("R9 after clear");
    end
    write_base(AW'(24'hFF_FFF0));
    pulse_set(N'(1) << 62);
    check_irq("R11 base wrap");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule